// File: doc/BRIEF.md
# CP0 Hazard Barrier Interlock

This block decides, one issue slot at a time, whether the instruction at the head of the issue queue of a pipelined core may leave for the pipeline. It keeps two up/down counts of in-flight instructions. The first counts every instruction in flight. The second counts only the instructions that write a system-control (CP0) register. It uses these counts to hold issue behind execution-hazard barriers. By default a barrier costs a bubble only when a CP0 writer is actually in flight, and then it waits for the whole pipe to drain. A slow-barrier setting makes a barrier drain the pipe whenever anything at all is in flight.

A second setting, automatic hazard mode, removes the need for most explicit barriers. With it on, an instruction that consumes CP0 state (register moves from CP0, interrupt enable or disable, exception and debug returns) waits until no CP0 writer is in flight. A register-indirect jump issued in kernel mode behaves exactly like its barrier form.

The issue side is a valid/ready pair with the ready side inverted (`iss_stall`). An offered instruction must keep `iss_valid` and its decode fields steady until it is accepted. An instruction is accepted on a rising clock edge where `iss_valid` is high and `iss_stall` is low. Every accepted instruction must later be reported exactly once on the graduation port, whether it graduated or was killed.

Top module: `cp0_hazard_ctl`

## Requirements
- R1: With slow mode off, an offered barrier (`iss_class` = 1) stalls while at least one CP0 writer is in flight. When no CP0 writer is in flight, it is accepted with no stall cycle, even if other instructions are in flight.
- R2: A barrier stall starts a drain that holds `iss_stall` high until both counts have reached zero. The stall falls in the cycle after the one in which the registered counts first read zero.
- R3: With slow mode on, an offered barrier stalls whenever any instruction is in flight, then drains as in R2. An empty pipe gives no stall.
- R4: With automatic mode on, a CP0 consumer (`iss_class` = 3) stalls while a CP0 writer is in flight. It is released one cycle after the CP0-writer count reaches zero, even if other instructions remain in flight.
- R5: With automatic mode on, a register jump (`iss_class` = 2) offered with `iss_kernel` high behaves as a barrier under R1 to R3.
- R6: A register jump offered with `iss_kernel` low never causes a hazard stall. With automatic mode off, neither register jumps nor CP0 consumers cause a hazard stall.
- R7: The two mode bits load from `cfg_slow_bar` and `cfg_auto_haz` on a `cfg_load` cycle. Both bits are clear after reset.
- R8: While `flush_pend` is high, an active drain never ends, even after both counts have reached zero.
- R9: When `PIPE_DEPTH` instructions are in flight, any offered instruction stalls. It is accepted in the cycle after a graduation frees a slot.
- R10: With no drain active and `iss_valid` low, `iss_stall` is low. Offers that are stalled do not add to the in-flight counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load the two mode bits this cycle |
| cfg_slow_bar | input | 1 | Slow-barrier mode value to load |
| cfg_auto_haz | input | 1 | Automatic hazard mode value to load |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_class | input | 2 | 0 plain, 1 barrier (including barrier jump forms), 2 register jump, 3 CP0 consumer |
| iss_wr_cp0 | input | 1 | The offered instruction writes a CP0 register |
| iss_kernel | input | 1 | The offered instruction runs in kernel mode |
| grad_valid | input | 1 | One in-flight instruction leaves the pipe this cycle |
| grad_wr_cp0 | input | 1 | The leaving instruction was a CP0 writer |
| flush_pend | input | 1 | A pipeline flush is pending |
| iss_stall | output | 1 | Hold issue; inverted ready |

## Verification
A CP0-writer count that is off by one has two possible effects at the port. A count that is too high leaves `iss_stall` stuck high behind the next barrier or consumer, and the drain never ends. A count that is too low lets such an instruction issue in the same cycle as its hazard. In both cases the error is visible on the first hazard-sensitive offer. A drain state that is released early shows as `iss_stall` falling one cycle sooner than the count rule allows. The bench samples every cycle of a drain, so an off-by-one timing error is caught on the edge where it occurs. Capacity errors show on the offer that follows `PIPE_DEPTH` accepted issues.

// File: rtl/cp0h_pkg.sv
package cp0h_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN   = 2'd0,
    CLS_BARRIER = 2'd1,
    CLS_REGJUMP = 2'd2,
    CLS_CP0READ = 2'd3
  } iss_class_e;

  typedef enum logic {
    DRN_CP0  = 1'b0,
    DRN_FULL = 1'b1
  } drain_kind_e;
endpackage

// File: rtl/cp0h_inflight_ctr.sv
module cp0h_inflight_ctr #(
  parameter int MAX = 11,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         is_zero,
  output logic         is_full
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc && !dec) begin
      cnt_q <= cnt_q + W'(1);
    end else if (dec && !inc) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign cnt     = cnt_q;
  assign is_zero = (cnt_q == '0);
  assign is_full = (cnt_q == W'(MAX));
endmodule

// File: rtl/cp0h_classify.sv
module cp0h_classify
  import cp0h_pkg::*;
(
  input  iss_class_e  cls,
  input  logic        kernel,
  input  logic        auto_haz,
  input  logic        slow_bar,
  input  logic        any_inflight,
  input  logic        cp0_inflight,
  output logic        need_stall,
  output drain_kind_e kind
);
  logic acts_as_barrier;
  logic acts_as_consumer;
  logic barrier_blocked;

  always_comb begin
    acts_as_barrier  = (cls == CLS_BARRIER) ||
                       (auto_haz && kernel && (cls == CLS_REGJUMP));
    acts_as_consumer = auto_haz && (cls == CLS_CP0READ);
    barrier_blocked  = slow_bar ? any_inflight : cp0_inflight;

    if (acts_as_barrier) begin
      need_stall = barrier_blocked;
      kind       = DRN_FULL;
    end else if (acts_as_consumer) begin
      need_stall = cp0_inflight;
      kind       = DRN_CP0;
    end else begin
      need_stall = 1'b0;
      kind       = DRN_CP0;
    end
  end
endmodule

// File: rtl/cp0h_drain_fsm.sv
module cp0h_drain_fsm
  import cp0h_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  drain_kind_e start_kind,
  input  logic        tot_zero,
  input  logic        cp0_zero,
  input  logic        flush_pend,
  output logic        draining
);
  logic        drain_q;
  drain_kind_e kind_q;
  logic        done;

  always_comb begin
    done = cp0_zero && !flush_pend && ((kind_q == DRN_CP0) || tot_zero);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_q <= 1'b0;
      kind_q  <= DRN_CP0;
    end else if (!drain_q) begin
      if (start) begin
        drain_q <= 1'b1;
        kind_q  <= start_kind;
      end
    end else if (done) begin
      drain_q <= 1'b0;
    end
  end

  assign draining = drain_q;
endmodule

// File: rtl/cp0_hazard_ctl.sv
module cp0_hazard_ctl
  import cp0h_pkg::*;
#(
  parameter int PIPE_DEPTH = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_load,
  input  logic       cfg_slow_bar,
  input  logic       cfg_auto_haz,
  input  logic       iss_valid,
  input  logic [1:0] iss_class,
  input  logic       iss_wr_cp0,
  input  logic       iss_kernel,
  input  logic       grad_valid,
  input  logic       grad_wr_cp0,
  input  logic       flush_pend,
  output logic       iss_stall
);
  localparam int CNT_W  = $clog2(PIPE_DEPTH + 1);
  localparam int N_CTR  = 2;
  localparam int IX_TOT = 0;
  localparam int IX_CP0 = 1;

  logic slow_q;
  logic auto_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= 1'b0;
      auto_q <= 1'b0;
    end else if (cfg_load) begin
      slow_q <= cfg_slow_bar;
      auto_q <= cfg_auto_haz;
    end
  end

  logic [N_CTR-1:0] ctr_inc;
  logic [N_CTR-1:0] ctr_dec;
  logic [N_CTR-1:0] ctr_zero;
  logic [N_CTR-1:0] ctr_full;
  logic [CNT_W-1:0] ctr_cnt [N_CTR];
  logic             accept;

  assign accept           = iss_valid && !iss_stall;
  assign ctr_inc[IX_TOT]  = accept;
  assign ctr_inc[IX_CP0]  = accept && iss_wr_cp0;
  assign ctr_dec[IX_TOT]  = grad_valid;
  assign ctr_dec[IX_CP0]  = grad_valid && grad_wr_cp0;

  for (genvar g = 0; g < N_CTR; g++) begin : g_ctr
    cp0h_inflight_ctr #(.MAX(PIPE_DEPTH), .W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (ctr_inc[g]),
      .dec     (ctr_dec[g]),
      .cnt     (ctr_cnt[g]),
      .is_zero (ctr_zero[g]),
      .is_full (ctr_full[g])
    );
  end

  logic [CNT_W-1:0] tot_cnt;
  logic [CNT_W-1:0] cp0_cnt;
  assign tot_cnt = ctr_cnt[IX_TOT];
  assign cp0_cnt = ctr_cnt[IX_CP0];

  logic        need_stall;
  drain_kind_e need_kind;

  cp0h_classify u_cls (
    .cls          (iss_class_e'(iss_class)),
    .kernel       (iss_kernel),
    .auto_haz     (auto_q),
    .slow_bar     (slow_q),
    .any_inflight (!ctr_zero[IX_TOT]),
    .cp0_inflight (!ctr_zero[IX_CP0]),
    .need_stall   (need_stall),
    .kind         (need_kind)
  );

  logic drain_q;

  cp0h_drain_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (iss_valid && need_stall),
    .start_kind (need_kind),
    .tot_zero   (ctr_zero[IX_TOT]),
    .cp0_zero   (ctr_zero[IX_CP0]),
    .flush_pend (flush_pend),
    .draining   (drain_q)
  );

  assign iss_stall = drain_q || (iss_valid && (need_stall || ctr_full[IX_TOT]));
endmodule

// File: rtl/cp0h_checker.sv
module cp0h_checker
  import cp0h_pkg::*;
#(
  parameter int PIPE_DEPTH = 11,
  parameter int CNT_W      = $clog2(PIPE_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic [1:0]       iss_class,
  input logic             iss_kernel,
  input logic             iss_stall,
  input logic             grad_valid,
  input logic             flush_pend,
  input logic [CNT_W-1:0] tot_cnt,
  input logic [CNT_W-1:0] cp0_cnt,
  input logic             drain_q,
  input logic             auto_q,
  input logic             slow_q
);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tot_cnt <= CNT_W'(PIPE_DEPTH));

  assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && tot_cnt == CNT_W'(PIPE_DEPTH)) |-> iss_stall);

  assert_cp0_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cp0_cnt <= tot_cnt);

  assert_grad_has_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grad_valid |-> tot_cnt != '0);

  assert_release_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drain_q) |-> ($past(cp0_cnt) == '0 && !$past(flush_pend)));

  assert_flush_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_q && flush_pend) |=> drain_q);

  assert_barrier_default_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_class == CLS_BARRIER && cp0_cnt != '0) |-> iss_stall);

  assert_barrier_slow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_class == CLS_BARRIER && slow_q && tot_cnt != '0) |-> iss_stall);

  assert_consumer_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && auto_q && iss_class == CLS_CP0READ && cp0_cnt != '0) |-> iss_stall);

  assert_kernel_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && auto_q && iss_kernel && iss_class == CLS_REGJUMP && cp0_cnt != '0)
      |-> iss_stall);

  assert_user_jump_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_kernel && iss_class == CLS_REGJUMP && !drain_q &&
     tot_cnt != CNT_W'(PIPE_DEPTH)) |-> !iss_stall);

  assert_idle_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_valid && !drain_q) |-> !iss_stall);
endmodule

bind cp0_hazard_ctl cp0h_checker #(.PIPE_DEPTH(PIPE_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_class  (iss_class),
  .iss_kernel (iss_kernel),
  .iss_stall  (iss_stall),
  .grad_valid (grad_valid),
  .flush_pend (flush_pend),
  .tot_cnt    (tot_cnt),
  .cp0_cnt    (cp0_cnt),
  .drain_q    (drain_q),
  .auto_q     (auto_q),
  .slow_q     (slow_q)
);

// File: tb/cp0_hazard_ctl_test.sv
module cp0_hazard_ctl_test;
  localparam int DEPTH = 11;
  localparam logic [1:0] C_PLAIN = 2'd0;
  localparam logic [1:0] C_BAR   = 2'd1;
  localparam logic [1:0] C_JUMP  = 2'd2;
  localparam logic [1:0] C_READ  = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0, cfg_slow_bar = 1'b0, cfg_auto_haz = 1'b0;
  logic iss_valid = 1'b0, iss_wr_cp0 = 1'b0, iss_kernel = 1'b0;
  logic [1:0] iss_class = 2'd0;
  logic grad_valid = 1'b0, grad_wr_cp0 = 1'b0, flush_pend = 1'b0;
  logic iss_stall;

  int checks = 0;
  int failures = 0;
  int m_tot = 0;
  int m_cp0 = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  cp0_hazard_ctl #(.PIPE_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_slow_bar(cfg_slow_bar),
    .cfg_auto_haz(cfg_auto_haz), .iss_valid(iss_valid), .iss_class(iss_class),
    .iss_wr_cp0(iss_wr_cp0), .iss_kernel(iss_kernel), .grad_valid(grad_valid),
    .grad_wr_cp0(grad_wr_cp0), .flush_pend(flush_pend), .iss_stall(iss_stall)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic expect_stall(input string req, input logic exp);
    @(negedge clk);
    checks++;
    if (iss_stall !== exp) begin
      failures++;
      $display("FAIL %s: iss_stall actual=%b expected=%b", req, iss_stall, exp);
    end
  endtask

  task automatic load_cfg(input logic slow, input logic autoh);
    cfg_slow_bar = slow; cfg_auto_haz = autoh; cfg_load = 1'b1;
    tick;
    cfg_load = 1'b0;
  endtask

  task automatic offer(input logic [1:0] cls, input logic kern, input logic wr);
    iss_valid = 1'b1; iss_class = cls; iss_kernel = kern; iss_wr_cp0 = wr;
  endtask

  task automatic take_offer;
    tick;
    m_tot++;
    if (iss_wr_cp0) m_cp0++;
    iss_valid = 1'b0; iss_wr_cp0 = 1'b0;
  endtask

  task automatic issue_one(input logic wr);
    offer(C_PLAIN, 1'b0, wr);
    take_offer;
  endtask

  task automatic grad_one(input logic wr);
    grad_valid = 1'b1; grad_wr_cp0 = wr;
    tick;
    grad_valid = 1'b0; grad_wr_cp0 = 1'b0;
    m_tot--;
    if (wr) m_cp0--;
  endtask

  task automatic drain_all;
    iss_valid = 1'b0;
    while (m_cp0 > 0) grad_one(1'b1);
    while (m_tot > 0) grad_one(1'b0);
    tick;
  endtask

  // Offer is stalled now; graduate one instruction and watch the release timing.
  task automatic release_seq(input logic wr, input string req);
    tick;
    grad_valid = 1'b1; grad_wr_cp0 = wr;
    m_tot--;
    if (wr) m_cp0--;
    expect_stall(req, 1'b1);
    tick;
    grad_valid = 1'b0; grad_wr_cp0 = 1'b0;
    expect_stall(req, 1'b1);
    tick;
    expect_stall(req, 1'b0);
    take_offer;
  endtask

  task automatic t_reset_state;
    expect_stall("R10 reset", 1'b0);
    issue_one(1'b1);
    offer(C_READ, 1'b1, 1'b0);
    expect_stall("R7 auto clear after reset", 1'b0);
    take_offer;
    drain_all;
  endtask

  task automatic t_barrier_default;
    load_cfg(1'b0, 1'b0);
    issue_one(1'b1);
    offer(C_BAR, 1'b1, 1'b0);
    expect_stall("R1 cp0 writer in flight", 1'b1);
    release_seq(1'b1, "R2 drain release");
    issue_one(1'b0);
    offer(C_BAR, 1'b1, 1'b0);
    expect_stall("R1 no bubble without cp0 writer", 1'b0);
    take_offer;
    drain_all;
  endtask

  task automatic t_barrier_slow;
    load_cfg(1'b1, 1'b0);
    offer(C_BAR, 1'b0, 1'b0);
    expect_stall("R3 empty pipe", 1'b0);
    take_offer;
    drain_all;
    issue_one(1'b0);
    offer(C_BAR, 1'b0, 1'b0);
    expect_stall("R3 slow barrier", 1'b1);
    release_seq(1'b0, "R3 slow drain");
    drain_all;
  endtask

  task automatic t_auto_consumer;
    load_cfg(1'b0, 1'b1);
    issue_one(1'b1);
    issue_one(1'b0);
    offer(C_READ, 1'b1, 1'b0);
    expect_stall("R4 consumer waits", 1'b1);
    release_seq(1'b1, "R4 cp0-only release");
    drain_all;
  endtask

  task automatic t_jumps;
    load_cfg(1'b0, 1'b1);
    issue_one(1'b1);
    offer(C_JUMP, 1'b1, 1'b0);
    expect_stall("R5 kernel jump barrier", 1'b1);
    release_seq(1'b1, "R5 kernel jump drain");
    issue_one(1'b1);
    offer(C_JUMP, 1'b0, 1'b0);
    expect_stall("R6 user jump", 1'b0);
    take_offer;
    load_cfg(1'b0, 1'b0);
    offer(C_JUMP, 1'b1, 1'b0);
    expect_stall("R6 kernel jump auto off", 1'b0);
    take_offer;
    offer(C_READ, 1'b1, 1'b0);
    expect_stall("R6 consumer auto off", 1'b0);
    take_offer;
    drain_all;
  endtask

  task automatic t_flush;
    load_cfg(1'b0, 1'b0);
    issue_one(1'b1);
    offer(C_BAR, 1'b1, 1'b0);
    expect_stall("R8 barrier", 1'b1);
    tick;
    grad_valid = 1'b1; grad_wr_cp0 = 1'b1; flush_pend = 1'b1;
    m_tot--; m_cp0--;
    expect_stall("R8 flush", 1'b1);
    tick;
    grad_valid = 1'b0; grad_wr_cp0 = 1'b0;
    expect_stall("R8 counts zero, flush held", 1'b1);
    tick;
    expect_stall("R8 still held", 1'b1);
    tick;
    flush_pend = 1'b0;
    expect_stall("R8 flush just dropped", 1'b1);
    tick;
    expect_stall("R8 released", 1'b0);
    take_offer;
    drain_all;
  endtask

  task automatic t_capacity;
    load_cfg(1'b0, 1'b0);
    for (int i = 0; i < DEPTH; i++) issue_one(1'b0);
    offer(C_PLAIN, 1'b0, 1'b0);
    expect_stall("R9 full", 1'b1);
    tick;
    expect_stall("R10 stalled offer held", 1'b1);
    tick;
    grad_valid = 1'b1; grad_wr_cp0 = 1'b0;
    m_tot--;
    expect_stall("R9 graduating", 1'b1);
    tick;
    grad_valid = 1'b0;
    expect_stall("R9 slot freed", 1'b0);
    take_offer;
    offer(C_PLAIN, 1'b0, 1'b0);
    expect_stall("R10 stalled offers not counted", 1'b1);
    iss_valid = 1'b0;
    expect_stall("R10 idle ready", 1'b0);
    drain_all;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick;
    t_reset_state;
    t_barrier_default;
    t_barrier_slow;
    t_auto_consumer;
    t_jumps;
    t_flush;
    t_capacity;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule